// File: doc/BRIEF.md
# Prime-Interleaved Strided Address Generator

This block turns one vector access into a series of per-lane memory requests for a memory split into seventeen interleaved modules. An access is described by a 24-bit base word address, a signed stride and an element count. Element k lives at word address base + k·stride. For each group of sixteen consecutive elements, the block outputs one module number (address mod 17) and one in-module offset (address div 17) for each lane. It also outputs a mask of the lanes that hold real elements, and a flag that is raised when two active lanes of the group hit the same module.

The block divides only at the start of an access. A serial divider splits the base and the stride into a quotient and a remainder. From then on, module and offset are held as running counters: each step adds the stride remainder to the module with a wrap at 17 and a carry into the offset. Groups are handed out over a valid/ready handshake. The whole access is framed by a start pulse, a busy level and a one-cycle done pulse. If an active element would fall below address 0, the access is aborted with an error, and that group is not presented.

Because 17 is prime, any stride that is not a multiple of 17 places the sixteen lanes of a full group in sixteen distinct modules. This covers column (stride 1), row (stride = column length) and diagonal (column length ± 1) walks through a column-major array.

Top module: `prime_stride_agu`

## Requirements
- R1: For every active lane, `lane_mod` field k (bits 5k+4..5k) equals the lane's word address mod 17, a value in 0..16.
- R2: For every active lane, `lane_off` field k (bits 20k+19..20k) equals floor(address / 17). Lane k of group g carries element 16g+k at address base + (16g+k)·stride, with stride read as a two's-complement 24-bit value. This holds for positive, zero and negative strides.
- R3: Groups are presented in element order, one per cycle in which `grp_valid` and `grp_ready` are both high. While `grp_valid` is high and `grp_ready` is low, `grp_valid`, `lane_mask`, `lane_mod`, `lane_off` and `conflict` hold their values.
- R4: Bit k of `lane_mask` is 1 exactly when element 16g+k is below the count. Full groups show all ones; the final partial group sets a contiguous run starting at lane 0.
- R5: `conflict` is 1 exactly when two active lanes of the presented group carry the same module number. Inactive lanes never cause it.
- R6: With a stride that is not a multiple of 17, no group reports a conflict. With a stride that is a multiple of 17 (including 0), every group with at least two active lanes reports a conflict.
- R7: If any active element's address is below 0, the groups before it are delivered and the group holding it is never presented. `err` then rises together with `done` and stays high until the next start.
- R8: A start accepted while idle with a nonzero count raises `busy` on the next cycle. `busy` stays high until the cycle in which `done` pulses for one cycle with `busy` low. A start with count 0 pulses `done` on the next cycle, and no group is presented.
- R9: After reset, `busy`, `done`, `err` and `grp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an access when idle; inputs below are sampled here |
| base | input | 24 | Word address of element 0 |
| stride | input | 24 | Signed two's-complement element spacing in words |
| count | input | 16 | Number of elements in the access |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse at the end of an access |
| err | output | 1 | Last access was aborted by an address below 0 |
| grp_valid | output | 1 | A lane group is presented |
| grp_ready | input | 1 | Consumer takes the presented group |
| lane_mask | output | 16 | Active lanes of the group |
| lane_mod | output | 80 | Module number per lane, 5 bits each, lane 0 lowest |
| lane_off | output | 320 | Offset within module per lane, 20 bits each, lane 0 lowest |
| conflict | output | 1 | Two active lanes share a module |

## Verification
A wrong remainder from the start-up divider shows up in lane 0 of the first group, so it is visible at the first `grp_valid`. A wrong wrap or carry in the lane chain corrupts the module or offset of one lane and of every lane after it within the same group. A stale group-start register shows up only on the next group of an access longer than sixteen elements. Errors in the remaining-element counter appear as a wrong mask, or as an extra or missing group at the tail of the access. The bench sweeps bases across more than one full module cycle and strides across ±40, so every remainder value and both wrap cases are exercised, together with multiples of 17, aborted accesses and partial tails.

// File: rtl/prime_stride_agu.sv
module prime_stride_agu #(
  parameter int AW    = 24,
  parameter int LANES = 16,
  parameter int MODS  = 17,
  parameter int CW    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [AW-1:0]        base,
  input  logic [AW-1:0]        stride,
  input  logic [CW-1:0]        count,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic                 grp_valid,
  input  logic                 grp_ready,
  output logic [LANES-1:0]     lane_mask,
  output logic [LANES*$clog2(MODS)-1:0] lane_mod,
  output logic [LANES*$clog2(((2**AW)-1)/MODS+1)-1:0] lane_off,
  output logic                 conflict
);
  localparam int MW  = $clog2(MODS);
  localparam int OW  = $clog2(((2**AW)-1)/MODS+1);
  localparam int SW  = AW + 2;
  localparam int BCW = $clog2(AW);
  localparam logic [MW:0] MODV = (MW+1)'(MODS);

  typedef enum logic [1:0] {S_IDLE, S_DIVB, S_DIVS, S_RUN} st_t;

  st_t                  st;
  logic [AW-1:0]        dv, smg;
  logic [MW-1:0]        rm, cur_m, stp_r;
  logic [BCW-1:0]       bc;
  logic signed [SW-1:0] cur_o, stp_q;
  logic [CW-1:0]        left;
  logic                 neg_s, err_q, done_q;

  logic [MW:0]          dtry;
  logic                 dge;
  logic [MW-1:0]        rm_n;
  logic [AW-1:0]        dq;
  logic signed [SW-1:0] dqx;

  assign dtry = {rm, dv[AW-1]};
  assign dge  = dtry >= MODV;
  assign rm_n = dge ? MW'(dtry - MODV) : dtry[MW-1:0];
  assign dq   = {dv[AW-2:0], dge};
  assign dqx  = {{(SW-AW){1'b0}}, dq};

  logic [MW-1:0]        lm   [LANES+1];
  logic signed [SW-1:0] lo   [LANES+1];
  logic [MODS-1:0]      used [LANES+1];
  logic [LANES-1:0]     hit, negv;

  assign lm[0]   = cur_m;
  assign lo[0]   = cur_o;
  assign used[0] = '0;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [MW:0] sm;
    logic        wrap;
    assign sm         = {1'b0, lm[k]} + {1'b0, stp_r};
    assign wrap       = sm >= MODV;
    assign lm[k+1]    = wrap ? MW'(sm - MODV) : sm[MW-1:0];
    assign lo[k+1]    = lo[k] + stp_q + {{(SW-1){1'b0}}, wrap};
    assign lane_mask[k] = left > CW'(k);
    assign negv[k]    = lo[k][SW-1];
    assign hit[k]     = lane_mask[k] & used[k][lm[k]];
    assign used[k+1]  = used[k] | (lane_mask[k] ? (MODS'(1) << lm[k]) : '0);
    assign lane_mod[k*MW +: MW] = lm[k];
    assign lane_off[k*OW +: OW] = lo[k][OW-1:0];
  end

  logic bad;
  assign bad       = |(lane_mask & negv);
  assign conflict  = |hit;
  assign grp_valid = (st == S_RUN) && !bad;
  assign busy      = st != S_IDLE;
  assign done      = done_q;
  assign err       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dv     <= '0;
      smg    <= '0;
      rm     <= '0;
      bc     <= '0;
      cur_m  <= '0;
      cur_o  <= '0;
      stp_r  <= '0;
      stp_q  <= '0;
      left   <= '0;
      neg_s  <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          err_q <= 1'b0;
          if (count == '0) done_q <= 1'b1;
          else begin
            dv    <= base;
            smg   <= stride[AW-1] ? -stride : stride;
            neg_s <= stride[AW-1];
            rm    <= '0;
            bc    <= '0;
            left  <= count;
            st    <= S_DIVB;
          end
        end
        S_DIVB: begin
          dv <= dq;
          rm <= rm_n;
          bc <= bc + 1'b1;
          if (bc == BCW'(AW-1)) begin
            cur_m <= rm_n;
            cur_o <= dqx;
            dv    <= smg;
            rm    <= '0;
            bc    <= '0;
            st    <= S_DIVS;
          end
        end
        S_DIVS: begin
          dv <= dq;
          rm <= rm_n;
          bc <= bc + 1'b1;
          if (bc == BCW'(AW-1)) begin
            if (!neg_s) begin
              stp_r <= rm_n;
              stp_q <= dqx;
            end else if (rm_n == '0) begin
              stp_r <= '0;
              stp_q <= -dqx;
            end else begin
              stp_r <= MW'(MODV - {1'b0, rm_n});
              stp_q <= ~dqx;
            end
            st <= S_RUN;
          end
        end
        S_RUN: begin
          if (bad) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (grp_ready) begin
            if (left <= CW'(LANES)) begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else begin
              left  <= left - CW'(LANES);
              cur_m <= lm[LANES];
              cur_o <= lo[LANES];
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module prime_stride_agu_chk #(
  parameter int LANES = 16,
  parameter int MODS  = 17,
  parameter int MW    = 5,
  parameter int OW    = 20
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  done,
  input logic                  err,
  input logic                  grp_valid,
  input logic                  grp_ready,
  input logic [LANES-1:0]      lane_mask,
  input logic [LANES*MW-1:0]   lane_mod,
  input logic [LANES*OW-1:0]   lane_off,
  input logic                  conflict
);
  logic        mods_ok;
  logic [47:0] a0, a1, a2;

  always_comb begin
    mods_ok = 1'b1;
    for (int k = 0; k < LANES; k++)
      if (lane_mask[k] && (int'(lane_mod[k*MW +: MW]) >= MODS)) mods_ok = 1'b0;
  end

  assign a0 = 48'(lane_off[0*OW +: OW]) * 48'(MODS) + 48'(lane_mod[0*MW +: MW]);
  assign a1 = 48'(lane_off[1*OW +: OW]) * 48'(MODS) + 48'(lane_mod[1*MW +: MW]);
  assign a2 = 48'(lane_off[2*OW +: OW]) * 48'(MODS) + 48'(lane_mod[2*MW +: MW]);

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid && !grp_ready |=> grp_valid && $stable(lane_mask) && $stable(lane_mod)
                                && $stable(lane_off) && $stable(conflict));
  // R4
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> lane_mask[0] && ((lane_mask & (lane_mask + 1'b1)) == '0));
  // R1
  mod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> mods_ok);
  // R2
  const_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid && lane_mask[2] |-> (a2 - a1) == (a1 - a0));
  // R5
  pair_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid && lane_mask[1] && (lane_mod[0 +: MW] == lane_mod[MW +: MW]) |-> conflict);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !grp_valid);
  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
endmodule

bind prime_stride_agu prime_stride_agu_chk #(
  .LANES(LANES), .MODS(MODS), .MW(MW), .OW(OW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .grp_valid(grp_valid), .grp_ready(grp_ready), .lane_mask(lane_mask),
  .lane_mod(lane_mod), .lane_off(lane_off), .conflict(conflict)
);

// File: tb/prime_stride_agu_tb.sv
module prime_stride_agu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;
  localparam int MW = 5;
  localparam int OW = 20;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, grp_ready = 1'b0;
  logic [23:0] base = '0, stride = '0;
  logic [15:0] count = '0;
  logic busy, done, err, grp_valid, conflict;
  logic [LANES-1:0] lane_mask;
  logic [LANES*MW-1:0] lane_mod;
  logic [LANES*OW-1:0] lane_off;

  int n_chk = 0, n_fail = 0, rc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prime_stride_agu u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
    .count(count), .busy(busy), .done(done), .err(err), .grp_valid(grp_valid),
    .grp_ready(grp_ready), .lane_mask(lane_mask), .lane_mod(lane_mod),
    .lane_off(lane_off), .conflict(conflict)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_group(longint b, longint s, int cnt, int g);
    logic [LANES-1:0] em;
    logic [16:0] seen;
    bit ec, okm, oko;
    longint am, xm, ao, xo;
    em = '0; seen = '0; ec = 0; okm = 1; oko = 1;
    am = 0; xm = 0; ao = 0; xo = 0;
    for (int k = 0; k < LANES; k++) begin
      longint idx, a;
      idx = 16*g + k;
      if (idx < cnt) begin
        a = b + idx*s;
        em[k] = 1'b1;
        if (seen[a % 17]) ec = 1;
        seen[a % 17] = 1'b1;
        if (okm && longint'(lane_mod[k*MW +: MW]) != a % 17) begin
          okm = 0; am = lane_mod[k*MW +: MW]; xm = a % 17;
        end
        if (oko && longint'(lane_off[k*OW +: OW]) != a / 17) begin
          oko = 0; ao = lane_off[k*OW +: OW]; xo = a / 17;
        end
      end
    end
    chk(okm, "R1", "lane module", am, xm);
    chk(oko, "R2", "lane offset", ao, xo);
    chk(lane_mask == em, "R4", "lane mask", lane_mask, em);
    if (em == '1 || s % 17 == 0)
      chk(conflict == ec, "R6", "conflict (stride rule)", conflict, ec);
    else
      chk(conflict == ec, "R5", "conflict (partial group)", conflict, ec);
  endtask

  task automatic run(longint b, longint s, int cnt);
    int eg, g, cyc;
    bit fin, snap;
    logic [LANES-1:0] sm_mask;
    logic [LANES*MW-1:0] sm_mod;
    logic [LANES*OW-1:0] sm_off;
    logic sm_c;
    eg = -1;
    for (int i = 0; i < cnt; i++)
      if (eg < 0 && b + i*s < 0) eg = i / 16;
    @(negedge clk);
    base = 24'(b); stride = 24'(s); count = 16'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == (cnt != 0), "R8", "busy after start", busy, cnt != 0);
    fin = 0; g = 0; cyc = 0; snap = 0;
    sm_mask = '0; sm_mod = '0; sm_off = '0; sm_c = 0;
    if (cnt == 0) begin
      chk(done == 1'b1, "R8", "done for empty access", done, 1);
      fin = 1;
    end
    while (!fin) begin
      @(negedge clk);
      cyc++; rc++;
      grp_ready = (rc % 4) != 2;
      if (grp_valid) begin
        if (snap)
          chk(lane_mask == sm_mask && lane_mod == sm_mod && lane_off == sm_off && conflict == sm_c,
              "R3", "hold while stalled", 0, 1);
        if (grp_ready) begin
          check_group(b, s, cnt, g);
          g++; snap = 0;
        end else begin
          sm_mask = lane_mask; sm_mod = lane_mod; sm_off = lane_off; sm_c = conflict;
          snap = 1;
        end
      end else if (snap) begin
        chk(0, "R3", "valid dropped while stalled", 0, 1);
        snap = 0;
      end
      if (done) begin
        fin = 1;
        chk(busy == 1'b0, "R8", "busy at done", busy, 0);
        chk(err == (eg >= 0), "R7", "error flag", err, eg >= 0);
        chk(g == ((eg >= 0) ? eg : (cnt + 15) / 16), "R7", "groups delivered",
            g, (eg >= 0) ? eg : (cnt + 15) / 16);
      end
      if (cyc > 3000) begin
        chk(0, "R8", "access never finished", cyc, 0);
        fin = 1;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog: actual %0d expected %0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(!busy && !done && !err && !grp_valid, "R9", "reset outputs",
        {busy, done, err, grp_valid}, 0);

    for (int b = 0; b < 34; b++) begin
      run(b, 1, 16);
      run(b, 5, 20);
    end
    for (int s = -40; s <= 40; s++) run(4000, s, 37);
    // R2 column-major walks, column length 23, row length 20
    run(1000, 1, 23);
    run(1000, 23, 20);
    run(1000, 24, 16);
    run(1022, 22, 16);
    // R4 tail sizes
    run(300, 3, 1);
    run(300, 3, 16);
    run(300, 3, 17);
    run(300, 3, 32);
    run(300, 3, 33);
    run(300, 3, 0);
    // R6 multiples of 17
    run(500, 34, 16);
    run(500, 0, 5);
    run(600, -17, 18);
    // R7 address below zero
    run(100, -7, 20);
    run(200, -9, 40);
    run(5, -17, 2);
    run(160, -10, 17);
    // extremes of the address range
    run(16777215, -8388608, 2);
    run(16776000, 70, 17);
    run(0, 8388607, 2);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule